// File: doc/BRIEF.md
# Reply Message Receiver with Parity-Tagged FIFO

This block listens for a reply frame on a demodulated tone-present input after the local transmitter has sent a command. A one-cycle `tx_done_i` pulse starts a fixed guard interval. When the guard interval ends, the block waits for the first tone edge. Tone pulses are decoded by their width into bits. Each group of nine bits becomes one byte plus its parity bit. Parity is odd. Every byte enters an eight-deep FIFO together with the received parity bit and a flag that records whether the parity check failed.

A host reads the block through two read addresses, status and FIFO. One FIFO entry takes two reads of the FIFO address: the first returns the data byte and the second returns the parity information, and the second read pops the entry. The status word reports whether data arrived, whether the message ended, whether any byte was lost to overflow and whether no reply came, plus the current fill level. The host may drain the FIFO while a message is still arriving. A level interrupt can be enabled for the end-of-message and no-reply events.

Top module: `rply_rx`

## Requirements
- R1: Listening begins exactly GUARD_CYC cycles after a `tx_done_i` pulse. Tone activity before that point produces no byte and does not start reception.
- R2: If no rising tone edge is seen within NOREPLY_CYC cycles after listening begins, status bit 3 (no reply) is set and the block returns to idle with no bytes stored.
- R3: A tone pulse that is high for fewer than ONE_MAX_CYC cycles decodes as 1, and any longer pulse decodes as 0. Bits arrive most significant first. Nine bits make one entry: eight data bits followed by the parity bit.
- R4: Parity is odd. The parity-error flag is set when the nine received bits hold an even number of ones.
- R5: With `rd_sel_i`=1, the first read of an entry returns the data byte. The second read returns {6'b0, parity_error, parity_bit}, with the parity bit in bit 0 and the error flag in bit 1, and that second read pops the entry. A read of an empty FIFO returns 0 and changes nothing.
- R6: With `rd_sel_i`=0, `rd_data_o` is the status word: bit0 data received, bit1 message ended, bit2 overflow, bit3 no reply, [7:4] number of stored entries (0 to DEPTH).
- R7: After at least one byte has been received, a silence of END_SIL_CYC cycles sets status bit 1 and ends reception.
- R8: A byte that arrives while the FIFO is full and not being popped is dropped, and status bit 2 is set. Bit 2 stays set until the next `tx_done_i`, which also clears bits 0, 1 and 3. Stored entries are kept.
- R9: A push and a pop in the same cycle both take effect, including when the FIFO is full. No entry is lost and the order is kept.
- R10: A status read (`rd_i`=1, `rd_sel_i`=0) clears bits 1 and 3. `irq_o` is high while `irq_en_i` is high and bit 1 or bit 3 is set.
- R11: After reset the status word is 0, `irq_o` is 0 and a FIFO read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_i | input | 1 | Demodulated tone present, asynchronous |
| tx_done_i | input | 1 | One-cycle pulse: local transmission finished |
| irq_en_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Read strobe, side effects at the clock edge |
| rd_sel_i | input | 1 | 0 selects status, 1 selects FIFO |
| rd_data_o | output | 8 | Read data for the selected address |
| irq_o | output | 1 | Level interrupt |

## Verification
A fault in the listen sequencer shows up in status as a no-reply flag that appears too early, too late or never. The bench checks this within a few hundred cycles of `tx_done_i`. A fault in the pulse decoder or the byte assembler shows up as wrong data or parity words on the very next FIFO read after the end-of-message flag. A fault in the FIFO pointers or in the read-phase flag shows up as reordered, duplicated or missing entries, or as a wrong fill level, the first time the bench drains a full FIFO after a push and a pop coincided.

// File: rtl/rply_pkg.sv
package rply_pkg;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_GUARD,
        LS_HUNT,
        LS_RECV
    } lstate_e;

    typedef struct packed {
        logic       perr;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

    localparam int unsigned SB_GOT  = 0;
    localparam int unsigned SB_END  = 1;
    localparam int unsigned SB_OVF  = 2;
    localparam int unsigned SB_NONE = 3;

endpackage

// File: rtl/rply_pulse_dec.sv
module rply_pulse_dec #(
    parameter int unsigned ONE_MAX = 10,
    parameter int unsigned END_SIL = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_i,
    input  logic en_i,
    output logic rise_o,
    output logic bit_vld_o,
    output logic bit_val_o,
    output logic quiet_o
);
    localparam int unsigned HW = $clog2(ONE_MAX + 1);
    localparam int unsigned LW = $clog2(END_SIL + 1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [HW-1:0] hi;
        logic [LW-1:0] lo;
    } dec_t;

    dec_t d_d, d_q;
    logic lvl, lvl_prev;

    assign lvl      = d_q.sync[1];
    assign lvl_prev = d_q.sync[2];

    always_comb begin
        d_d      = d_q;
        d_d.sync = {d_q.sync[1:0], tone_i};
        if (lvl) begin
            d_d.lo = '0;
            if (!lvl_prev)
                d_d.hi = HW'(1);
            else if (d_q.hi != HW'(ONE_MAX))
                d_d.hi = d_q.hi + HW'(1);
        end else if (d_q.lo != LW'(END_SIL)) begin
            d_d.lo = d_q.lo + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign rise_o    = lvl & ~lvl_prev;
    assign bit_vld_o = en_i & ~lvl & lvl_prev;
    assign bit_val_o = (d_q.hi < HW'(ONE_MAX));
    assign quiet_o   = (d_q.lo == LW'(END_SIL));

endmodule

// File: rtl/rply_byte_asm.sv
module rply_byte_asm
    import rply_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_i,
    input  logic      bit_vld_i,
    input  logic      bit_val_i,
    output logic      byte_vld_o,
    output rx_entry_t entry_o
);
    typedef struct packed {
        logic [7:0] sh;
        logic [3:0] n;
    } asm_t;

    asm_t a_d, a_q;
    logic [8:0] nine;

    assign nine = {a_q.sh, bit_val_i};

    always_comb begin
        a_d = a_q;
        if (clr_i) begin
            a_d = '0;
        end else if (bit_vld_i) begin
            if (a_q.n == 4'd8) begin
                a_d = '0;
            end else begin
                a_d.sh = nine[7:0];
                a_d.n  = a_q.n + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign byte_vld_o    = bit_vld_i & ~clr_i & (a_q.n == 4'd8);
    assign entry_o.data  = nine[8:1];
    assign entry_o.par   = nine[0];
    assign entry_o.perr  = ~(^nine);

endmodule

// File: rtl/rply_fifo.sv
module rply_fifo
    import rply_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  rx_entry_t     entry_i,
    input  logic          pop_i,
    output rx_entry_t     head_o,
    output logic [CW-1:0] cnt_o,
    output logic          empty_o,
    output logic          drop_o
);
    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_pop, do_push;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_pop  = pop_i & (f_q.cnt != '0);
    assign do_push = push_i & ((f_q.cnt != CW'(DEPTH)) | do_pop);

    always_comb begin
        f_d = f_q;
        if (do_push) begin
            f_d.mem[f_q.wp] = entry_i;
            f_d.wp          = step(f_q.wp);
        end
        if (do_pop)
            f_d.rp = step(f_q.rp);
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + CW'(1);
            2'b01:   f_d.cnt = f_q.cnt - CW'(1);
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_o  = f_q.mem[f_q.rp];
    assign cnt_o   = f_q.cnt;
    assign empty_o = (f_q.cnt == '0);
    assign drop_o  = push_i & ~do_push;

endmodule

// File: rtl/rply_rx.sv
module rply_rx
    import rply_pkg::*;
#(
    parameter int unsigned GUARD_CYC   = 50000,
    parameter int unsigned NOREPLY_CYC = 200000,
    parameter int unsigned ONE_MAX_CYC = 7500,
    parameter int unsigned END_SIL_CYC = 60000,
    parameter int unsigned DEPTH       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_i,
    input  logic       tx_done_i,
    input  logic       irq_en_i,
    input  logic       rd_i,
    input  logic       rd_sel_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o
);
    localparam int unsigned TMAX = (GUARD_CYC > NOREPLY_CYC) ? GUARD_CYC : NOREPLY_CYC;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned CW   = $clog2(DEPTH + 1);

    typedef struct packed {
        lstate_e       st;
        logic [TW-1:0] tmr;
        logic          got;
        logic          msg_end;
        logic          ovf;
        logic          none;
        logic          half;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          rise, bit_vld, bit_val, quiet;
    logic          byte_vld, push, pop, drop, empty;
    rx_entry_t     new_ent, head;
    logic [CW-1:0] cnt;
    logic          rd_fifo, rd_stat;
    logic [7:0]    status;

    rply_pulse_dec #(.ONE_MAX(ONE_MAX_CYC), .END_SIL(END_SIL_CYC)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .tone_i   (tone_i),
        .en_i     (c_q.st == LS_RECV),
        .rise_o   (rise),
        .bit_vld_o(bit_vld),
        .bit_val_o(bit_val),
        .quiet_o  (quiet)
    );

    rply_byte_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (c_q.st != LS_RECV),
        .bit_vld_i (bit_vld),
        .bit_val_i (bit_val),
        .byte_vld_o(byte_vld),
        .entry_o   (new_ent)
    );

    rply_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .entry_i(new_ent),
        .pop_i  (pop),
        .head_o (head),
        .cnt_o  (cnt),
        .empty_o(empty),
        .drop_o (drop)
    );

    assign push    = byte_vld;
    assign rd_fifo = rd_i & rd_sel_i & ~empty;
    assign rd_stat = rd_i & ~rd_sel_i;
    assign pop     = rd_fifo & c_q.half;

    always_comb begin
        status          = '0;
        status[7:4]     = 4'(cnt);
        status[SB_GOT]  = c_q.got;
        status[SB_END]  = c_q.msg_end;
        status[SB_OVF]  = c_q.ovf;
        status[SB_NONE] = c_q.none;
    end

    always_comb begin
        if (!rd_sel_i)
            rd_data_o = status;
        else if (empty)
            rd_data_o = '0;
        else if (c_q.half)
            rd_data_o = {6'b0, head.perr, head.par};
        else
            rd_data_o = head.data;
    end

    always_comb begin
        c_d = c_q;
        if (rd_fifo)
            c_d.half = ~c_q.half;
        if (rd_stat) begin
            c_d.msg_end = 1'b0;
            c_d.none    = 1'b0;
        end
        if (byte_vld)
            c_d.got = 1'b1;
        if (drop)
            c_d.ovf = 1'b1;

        unique case (c_q.st)
            LS_GUARD: begin
                if (c_q.tmr == TW'(GUARD_CYC - 1)) begin
                    c_d.st  = LS_HUNT;
                    c_d.tmr = '0;
                end else begin
                    c_d.tmr = c_q.tmr + TW'(1);
                end
            end
            LS_HUNT: begin
                if (rise) begin
                    c_d.st = LS_RECV;
                end else if (c_q.tmr == TW'(NOREPLY_CYC - 1)) begin
                    c_d.none = 1'b1;
                    c_d.st   = LS_IDLE;
                end else begin
                    c_d.tmr = c_q.tmr + TW'(1);
                end
            end
            LS_RECV: begin
                if (quiet) begin
                    if (c_d.got) c_d.msg_end = 1'b1;
                    else         c_d.none    = 1'b1;
                    c_d.st = LS_IDLE;
                end
            end
            default: ;
        endcase

        if (tx_done_i) begin
            c_d.st      = LS_GUARD;
            c_d.tmr     = '0;
            c_d.got     = 1'b0;
            c_d.msg_end = 1'b0;
            c_d.ovf     = 1'b0;
            c_d.none    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: LS_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign irq_o = irq_en_i & (c_q.msg_end | c_q.none);

endmodule

// File: rtl/rply_rx_chk.sv
module rply_rx_chk
    import rply_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input lstate_e       st,
    input logic [CW-1:0] cnt,
    input logic          push,
    input logic          got,
    input logic          msg_end,
    input logic          ovf,
    input logic          none,
    input logic          irq_o,
    input logic          rd_i,
    input logic          rd_sel_i,
    input logic          tx_done_i
);
    AST_GUARD_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LS_GUARD) |-> !push);  // R1
    AST_NOREPLY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(none) |-> !got);  // R2
    AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));  // R6
    AST_END_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_end) |-> got);  // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(cnt) == CW'(DEPTH)));  // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt + CW'(1) == $past(cnt)));  // R9
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !rd_sel_i && st == LS_IDLE && !tx_done_i) |=> !irq_o);  // R10
endmodule

bind rply_rx rply_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (c_q.st),
    .cnt      (cnt),
    .push     (push),
    .got      (c_q.got),
    .msg_end  (c_q.msg_end),
    .ovf      (c_q.ovf),
    .none     (c_q.none),
    .irq_o    (irq_o),
    .rd_i     (rd_i),
    .rd_sel_i (rd_sel_i),
    .tx_done_i(tx_done_i)
);

// File: tb/rply_rx_test.sv
module rply_rx_test;
    localparam int GUARD = 20;
    localparam int NOREP = 200;
    localparam int ONEMX = 10;
    localparam int ENDSL = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_i = 1'b0;
    logic       tx_done_i = 1'b0;
    logic       irq_en_i = 1'b1;
    logic       rd_i = 1'b0;
    logic       rd_sel_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rply_rx #(
        .GUARD_CYC(GUARD), .NOREPLY_CYC(NOREP),
        .ONE_MAX_CYC(ONEMX), .END_SIL_CYC(ENDSL), .DEPTH(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tone_i(tone_i), .tx_done_i(tx_done_i),
        .irq_en_i(irq_en_i), .rd_i(rd_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic odd_par(logic [7:0] d);
        return ~(^d);
    endfunction

    task automatic peek(output logic [7:0] v);
        @(negedge clk);
        rd_sel_i = 1'b0;
        rd_i = 1'b0;
        #1 v = rd_data_o;
    endtask

    task automatic rd_word(input logic sel, output logic [7:0] v);
        @(negedge clk);
        rd_sel_i = sel;
        rd_i = 1'b1;
        #1 v = rd_data_o;
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    task automatic pulse_tx;
        @(negedge clk);
        tx_done_i = 1'b1;
        @(negedge clk);
        tx_done_i = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        tone_i = 1'b1;
        repeat (b ? 4 : 16) @(negedge clk);
        tone_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic p);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        send_bit(p);
    endtask

    task automatic expect_entry(string req, logic [7:0] d, logic [7:0] flags);
        logic [7:0] v;
        rd_word(1'b1, v);
        check(req, v, d);
        rd_word(1'b1, v);
        check(req, v, flags);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(v);
        check("R11 status", v, 8'h00);
        check("R11 irq", {7'b0, irq_o}, 8'h00);
        rd_word(1'b1, v);
        check("R11 fifo empty", v, 8'h00);
    endtask

    task automatic t_noreply;
        logic [7:0] v;
        pulse_tx();
        repeat (GUARD + NOREP - 10) @(negedge clk);
        peek(v);
        check("R2 not yet", v, 8'h00);
        repeat (20) @(negedge clk);
        peek(v);
        check("R2 no reply", v, 8'h08);
        check("R10 irq set", {7'b0, irq_o}, 8'h01);
        rd_word(1'b0, v);
        check("R10 status read", v, 8'h08);
        peek(v);
        check("R10 cleared", v, 8'h00);
        check("R10 irq clear", {7'b0, irq_o}, 8'h00);
    endtask

    task automatic t_guard;
        logic [7:0] v;
        pulse_tx();
        repeat (2) @(negedge clk);
        tone_i = 1'b1;
        repeat (4) @(negedge clk);
        tone_i = 1'b0;
        repeat (GUARD + NOREP + 20) @(negedge clk);
        peek(v);
        check("R1 guard pulse ignored", v, 8'h08);
        rd_word(1'b0, v);
    endtask

    task automatic t_message;
        logic [7:0] v;
        pulse_tx();
        repeat (GUARD + 10) @(negedge clk);
        send_byte(8'hA5, 1'b1);
        send_byte(8'h3C, 1'b1);
        peek(v);
        check("R7 not ended yet", v, 8'h21);
        repeat (ENDSL + 20) @(negedge clk);
        peek(v);
        check("R6 R7 status", v, 8'h23);
        check("R10 irq on end", {7'b0, irq_o}, 8'h01);
        rd_word(1'b0, v);
        expect_entry("R3 R5 entry A5", 8'hA5, 8'h01);
        expect_entry("R3 R5 entry 3C", 8'h3C, 8'h01);
        peek(v);
        check("R6 after drain", v, 8'h01);
        rd_word(1'b1, v);
        check("R5 empty read", v, 8'h00);
        peek(v);
        check("R5 empty read no effect", v, 8'h01);
    endtask

    task automatic t_parity;
        logic [7:0] v;
        pulse_tx();
        repeat (GUARD + 10) @(negedge clk);
        send_byte(8'h07, 1'b1);
        send_byte(8'h80, 1'b0);
        send_byte(8'hFF, 1'b0);
        repeat (ENDSL + 20) @(negedge clk);
        peek(v);
        check("R6 three stored", v, 8'h33);
        expect_entry("R4 even ones flagged", 8'h07, 8'h03);
        expect_entry("R4 odd ok par0", 8'h80, 8'h00);
        expect_entry("R4 all ones par0 flagged", 8'hFF, 8'h02);
        rd_word(1'b0, v);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        pulse_tx();
        repeat (GUARD + 10) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            logic [7:0] d;
            d = 8'h10 + 8'(i);
            send_byte(d, odd_par(d));
        end
        repeat (ENDSL + 20) @(negedge clk);
        peek(v);
        check("R8 overflow status", v, 8'h87);
    endtask

    task automatic t_same_cycle;
        logic [7:0] v;
        logic [7:0] d;
        pulse_tx();
        peek(v);
        check("R8 tx clears flags keeps entries", v, 8'h80);
        repeat (GUARD + 10) @(negedge clk);
        d = 8'h5A;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        @(negedge clk);
        tone_i = 1'b1;
        repeat (4) @(negedge clk);
        tone_i = 1'b0;
        @(negedge clk);
        rd_sel_i = 1'b1;
        rd_i = 1'b1;
        #1 check("R9 head data", rd_data_o, 8'h10);
        @(negedge clk);
        #1 check("R9 head flags", rd_data_o, {7'b0, odd_par(8'h10)});
        @(negedge clk);
        rd_i = 1'b0;
        repeat (ENDSL + 20) @(negedge clk);
        peek(v);
        check("R9 full push with pop", v, 8'h83);
        for (int i = 1; i < 8; i++) begin
            logic [7:0] e;
            e = 8'h10 + 8'(i);
            expect_entry("R9 order kept", e, {7'b0, odd_par(e)});
        end
        expect_entry("R9 new byte last", 8'h5A, 8'h01);
        peek(v);
        check("R9 drained", v, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_noreply();
        t_guard();
        t_message();
        t_parity();
        t_overflow();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule